// File: doc/BRIEF.md
# Sound Command Interrupt Flip-Flop

This block lets a main processor interrupt a sound processor by writing a control register. It behaves like an edge-triggered flip-flop whose data input is held at one and whose preset is never used. One chosen bit of each written byte drives the flip-flop's clock, either directly or through an inverter. An edge is detected by comparing each new write against the stored value of that bit from the write before. The sound processor's interrupt acknowledge clears the flip-flop, and during that acknowledge the block places an all-ones vector on its vector output.

The default build clocks the flip-flop from the inverted bit 3 and uses bit 4 of the same byte as a global sound-disable control. Other builds can clock from bit 0, inverted or not, and can leave out the disable control. A strobe build ignores the data. It raises the request on any write to the register and drops it when the sound processor reads its command latch.

The request is held in a two-state machine. The states are ST_IDLE (no request, `irq_n` high) and ST_PENDING (request raised, `irq_n` low). The SET transition goes from ST_IDLE to ST_PENDING on a set event. The CLEAR transition goes from ST_PENDING to ST_IDLE on a clear event. CLEAR_WINS is the case where a set event and a clear event arrive in the same cycle; the machine then lands in ST_IDLE. A HOLD transition keeps the current state in every other cycle.

Top module: `snd_irq_ff`

## Requirements
- R1: After reset, `irq_n` is 1 and `snd_en` is 1. The stored trigger bit starts at 1 in inverted builds and at 0 otherwise. In the default build, a first write with bit 3 at 0 therefore raises the request.
- R2: In the default build, a write with bit 3 at 0, following a write with bit 3 at 1, drives `irq_n` to 0 from the clock edge that takes the write. Once low, `irq_n` stays low until a clear event.
- R3: In the default build, a write that takes bit 3 from 0 to 1, or that keeps bit 3 unchanged, does not raise the request. The other data bits have no effect on the request.
- R4: In the edge builds, `int_ack` high at a clock edge clears the request, so `irq_n` is 1 after that edge.
- R5: When a set event and a clear event occur in the same cycle, the clear wins and `irq_n` is 1 after the edge.
- R6: `vec` is 8'hFF while `int_ack` is high and 8'h00 otherwise. It follows `int_ack` within the same cycle.
- R7: In the build with a disable control, `snd_en` is the inverse of bit 4 of the most recent write. In builds without it, `snd_en` is always 1.
- R8: In the build that clocks from bit 0 without inversion, a write with bit 0 at 1, following a write with bit 0 at 0, raises the request.
- R9: In the strobe build, every write raises the request and `latch_rd` clears it. `int_ack` does not clear the request in this build.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the trigger register, one cycle per write |
| wr_data | input | DATA_W | Byte written to the trigger register |
| int_ack | input | 1 | Interrupt acknowledge from the sound processor |
| latch_rd | input | 1 | Command latch read by the sound processor (strobe build only) |
| irq_n | output | 1 | Interrupt request to the sound processor, active low |
| vec | output | DATA_W | Vector byte, all ones during acknowledge |
| snd_en | output | 1 | Global sound enable |

## Verification
The properties assume that `wr_en`, `int_ack` and `latch_rd` are synchronous, single-cycle qualifiers sampled at the rising edge. They also assume these inputs are stable around that edge, and that `wr_data` is meaningful only while `wr_en` is high. The stimulus sets every input one time unit after a rising edge and holds it for the whole cycle. The clear inputs are raised on their own, at the same time as a write, and while no request is pending, so every transition of the state machine is reached. Consecutive writes cover every value of the first byte against sixteen spread values of the second byte.

// File: rtl/snd_irq_pkg.sv
package snd_irq_pkg;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_PENDING = 1'b1
    } irq_state_t;

endpackage

// File: rtl/snd_trig_edge.sv
// Set-event source: either a stored-bit edge detector or a plain write strobe.
module snd_trig_edge #(
    parameter bit TRIG_INVERT = 1'b1,
    parameter bit STROBE_MODE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_bit,
    output logic set_req
);

    // Reset value chosen so the flip-flop clock level starts low.
    localparam logic LAST_RST = TRIG_INVERT;

    generate
        if (STROBE_MODE) begin : g_strobe
            logic unused_strobe;
            assign unused_strobe = clk ^ rst_n ^ wr_bit;
            assign set_req       = wr_en;
        end else begin : g_edge
            logic last_bit;
            logic lvl_old;
            logic lvl_new;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    last_bit <= LAST_RST;
                end else if (wr_en) begin
                    last_bit <= wr_bit;
                end
            end

            always_comb begin
                lvl_old = last_bit ^ TRIG_INVERT;
                lvl_new = wr_bit ^ TRIG_INVERT;
                set_req = wr_en && lvl_new && !lvl_old;
            end
        end
    endgenerate

endmodule

// File: rtl/snd_disable_reg.sv
// Optional sound-disable register fed from one bit of the written byte.
module snd_disable_reg #(
    parameter bit HAS_DISABLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic dis_bit,
    output logic snd_en
);

    generate
        if (HAS_DISABLE) begin : g_dis
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    snd_en <= 1'b1;
                end else if (wr_en) begin
                    snd_en <= !dis_bit;
                end
            end
        end else begin : g_nodis
            logic unused_dis;
            assign unused_dis = clk ^ rst_n ^ wr_en ^ dis_bit;
            assign snd_en     = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/snd_irq_fsm.sv
// Request state machine: ST_IDLE <-> ST_PENDING, clear has priority.
module snd_irq_fsm
    import snd_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic irq_n
);

    irq_state_t state_q;
    irq_state_t state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: SET, CLEAR, CLEAR_WINS, HOLD.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (clr_req) begin
                    state_d = ST_IDLE;
                end else if (set_req) begin
                    state_d = ST_PENDING;
                end
            end
            ST_PENDING: begin
                if (clr_req) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        unique case (state_q)
            ST_PENDING: irq_n = 1'b0;
            default:    irq_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/snd_irq_ff.sv
module snd_irq_ff #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned TRIG_BIT    = 3,
    parameter bit          TRIG_INVERT = 1'b1,
    parameter bit          HAS_DISABLE = 1'b1,
    parameter int unsigned DIS_BIT     = 4,
    parameter bit          STROBE_MODE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              int_ack,
    input  logic              latch_rd,
    output logic              irq_n,
    output logic [DATA_W-1:0] vec,
    output logic              snd_en
);

    localparam logic [DATA_W-1:0] ACK_VEC = '1;

    logic set_req;
    logic clr_req;
    logic unused_in;

    generate
        if (STROBE_MODE) begin : g_clr_rd
            assign clr_req = latch_rd;
        end else begin : g_clr_ack
            assign clr_req = int_ack;
        end
    endgenerate

    assign unused_in = ^{wr_data, latch_rd};

    snd_trig_edge #(
        .TRIG_INVERT (TRIG_INVERT),
        .STROBE_MODE (STROBE_MODE)
    ) u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_bit  (wr_data[TRIG_BIT]),
        .set_req (set_req)
    );

    snd_irq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (set_req),
        .clr_req (clr_req),
        .irq_n   (irq_n)
    );

    snd_disable_reg #(
        .HAS_DISABLE (HAS_DISABLE)
    ) u_dis (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .dis_bit (wr_data[DIS_BIT]),
        .snd_en  (snd_en)
    );

    always_comb begin
        vec = int_ack ? ACK_VEC : '0;
    end

endmodule

// File: rtl/snd_irq_chk.sv
module snd_irq_chk #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned DIS_BIT     = 4,
    parameter bit          HAS_DISABLE = 1'b1,
    parameter bit          STROBE_MODE = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              int_ack,
    input logic              latch_rd,
    input logic              irq_n,
    input logic [DATA_W-1:0] vec,
    input logic              snd_en
);

    logic clr_sig;
    assign clr_sig = STROBE_MODE ? latch_rd : int_ack;

    // R2: a pending request is held until a clear event.
    p_pend_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !clr_sig) |=> !irq_n);

    // R3: without a write the request cannot rise.
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_n && !wr_en) |=> irq_n);

    // R4: a clear event drops a pending request.
    p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && clr_sig) |=> irq_n);

    // R5: clear beats a simultaneous write.
    p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_sig && wr_en) |=> irq_n);

    // R6: vector follows the acknowledge.
    p_vector_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack |-> (vec == {DATA_W{1'b1}}));

    p_vector_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !int_ack |-> (vec == '0));

    generate
        if (HAS_DISABLE) begin : g_dis_chk
            // R7: enable is the inverse of the last disable bit.
            p_snd_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en |=> (snd_en == !$past(wr_data[DIS_BIT])));
            p_snd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
                !wr_en |=> $stable(snd_en));
        end else begin : g_nodis_chk
            p_snd_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
                snd_en);
        end
        if (STROBE_MODE) begin : g_strobe_chk
            // R9: any write without latch read raises the request.
            p_strobe_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && !latch_rd) |=> !irq_n);
        end
    endgenerate

endmodule

bind snd_irq_ff snd_irq_chk #(
    .DATA_W      (DATA_W),
    .DIS_BIT     (DIS_BIT),
    .HAS_DISABLE (HAS_DISABLE),
    .STROBE_MODE (STROBE_MODE)
) u_snd_irq_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .int_ack  (int_ack),
    .latch_rd (latch_rd),
    .irq_n    (irq_n),
    .vec      (vec),
    .snd_en   (snd_en)
);

// File: tb/test_snd_irq_ff.sv
module test_snd_irq_ff;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       int_ack = 1'b0;
    logic       latch_rd = 1'b0;

    logic       irq_n_a, irq_n_b, irq_n_c;
    logic [7:0] vec_a, vec_b, vec_c;
    logic       snd_en_a, snd_en_b, snd_en_c;

    int n_tests = 0;
    int n_fail  = 0;

    // Bench models of the requirements.
    bit last_a, pend_a, en_a;
    bit last_b, pend_b;
    bit pend_c;

    always #5 clk = ~clk;

    // Default build: inverted bit 3, disable on bit 4.
    snd_irq_ff i_snd_irq_ff (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .int_ack(int_ack), .latch_rd(latch_rd),
        .irq_n(irq_n_a), .vec(vec_a), .snd_en(snd_en_a)
    );

    // Bit 0 without inversion, no disable.
    snd_irq_ff #(.TRIG_BIT(0), .TRIG_INVERT(1'b0), .HAS_DISABLE(1'b0)) i_snd_irq_ff_b (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .int_ack(int_ack), .latch_rd(latch_rd),
        .irq_n(irq_n_b), .vec(vec_b), .snd_en(snd_en_b)
    );

    // Strobe build.
    snd_irq_ff #(.HAS_DISABLE(1'b0), .STROBE_MODE(1'b1)) i_snd_irq_ff_c (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .int_ack(int_ack), .latch_rd(latch_rd),
        .irq_n(irq_n_c), .vec(vec_c), .snd_en(snd_en_c)
    );

    task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "irq_n default", {7'd0, irq_n_a}, {7'd0, !pend_a});
        chk(tag, "irq_n bit0",    {7'd0, irq_n_b}, {7'd0, !pend_b});
        chk(tag, "irq_n strobe",  {7'd0, irq_n_c}, {7'd0, !pend_c});
        chk(tag, "snd_en default", {7'd0, snd_en_a}, {7'd0, en_a});
        chk("R7", "snd_en bit0 build", {7'd0, snd_en_b}, 8'd1);
        chk("R7", "snd_en strobe build", {7'd0, snd_en_c}, 8'd1);
        chk("R6", "vec", vec_a, int_ack ? 8'hFF : 8'h00);
        chk("R6", "vec strobe", vec_c, int_ack ? 8'hFF : 8'h00);
    endtask

    // One clock cycle of stimulus, model update and checks.
    task automatic step(input bit w, input logic [7:0] d, input bit a, input bit r, input string tag);
        bit edge_a, edge_b;
        wr_en = w; wr_data = d; int_ack = a; latch_rd = r;
        @(posedge clk);
        #1;
        edge_a = w && last_a && !d[3];
        edge_b = w && !last_b && d[0];
        pend_a = a ? 1'b0 : (pend_a || edge_a);
        pend_b = a ? 1'b0 : (pend_b || edge_b);
        pend_c = r ? 1'b0 : (pend_c || w);
        if (w) begin
            last_a = d[3];
            last_b = d[0];
            en_a   = !d[4];
        end
        check_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        last_a = 1'b1; pend_a = 1'b0; en_a = 1'b1;
        last_b = 1'b0; pend_b = 1'b0;
        pend_c = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1", "irq_n after reset", {7'd0, irq_n_a}, 8'd1);
        chk("R1", "snd_en after reset", {7'd0, snd_en_a}, 8'd1);
        chk("R1", "irq_n strobe after reset", {7'd0, irq_n_c}, 8'd1);
        step(1'b0, 8'h00, 1'b0, 1'b0, "R1");
        // R1: first write with bit 3 low sets the default build
        step(1'b1, 8'h00, 1'b0, 1'b0, "R1");
        chk("R1", "first write sets", {7'd0, irq_n_a}, 8'd0);
        // R9: int_ack does not clear the strobe build
        step(1'b0, 8'h00, 1'b1, 1'b0, "R4 R9");
        chk("R9", "ack ignored in strobe build", {7'd0, irq_n_c}, 8'd0);
        step(1'b0, 8'h00, 1'b0, 1'b1, "R9");
        // Sweep consecutive write pairs.
        for (int a = 0; a < 256; a++) begin
            for (int k = 0; k < 16; k++) begin
                step(1'b1, a[7:0], 1'b0, 1'b0, "R2 R3 R8 R9");
                step(1'b0, 8'h00, 1'b1, 1'b1, "R4");
                step(1'b1, 8'(k * 17), 1'b0, 1'b0, "R2 R3 R7 R8 R9");
                step(1'b0, 8'h00, 1'b0, 1'b0, "R2 R3");
            end
        end
        // R5: set edge and clear in the same cycle
        step(1'b1, 8'h08, 1'b1, 1'b1, "R5");
        step(1'b1, 8'h01, 1'b1, 1'b1, "R5");
        chk("R5", "clear wins default", {7'd0, irq_n_a}, 8'd1);
        chk("R5", "clear wins strobe", {7'd0, irq_n_c}, 8'd1);
        // R5: clear wins while already pending
        step(1'b1, 8'h08, 1'b0, 1'b0, "R2");
        step(1'b1, 8'h00, 1'b0, 1'b0, "R2");
        step(1'b1, 8'h08, 1'b1, 1'b1, "R5");
        chk("R5", "clear wins while pending", {7'd0, irq_n_a}, 8'd1);
        // R7: disable bit
        step(1'b1, 8'h10, 1'b0, 1'b0, "R7");
        chk("R7", "bit 4 set disables", {7'd0, snd_en_a}, 8'd0);
        step(1'b1, 8'hEF, 1'b0, 1'b0, "R7");
        chk("R7", "bit 4 clear enables", {7'd0, snd_en_a}, 8'd1);
        wr_en = 1'b0; int_ack = 1'b0; latch_rd = 1'b0;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule